// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This block turns a two-part logical address (a segment number and an offset within that segment) into a physical address. It looks the segment up in a small table held in internal registers. Each table entry holds the segment's physical start address, its length in bytes, a valid flag and three permission flags: read, write and execute. A separate length register sets how many segments are legal. Both the table and the length register are written through a configuration port.

Each request carries an access type. The unit checks, in a fixed order, that the segment number is legal, that the entry is valid, that the offset lies inside the segment, and that the entry permits the access. A request that passes every check returns the start address plus the offset. A request that fails returns a fault code that names the first check it failed. Results come out one clock after the request, so a processor pipeline can issue one request per cycle.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0, the length register is 0 and every table entry is invalid. A request issued right after reset therefore returns fault 1.
- R2: A request whose segment number is greater than or equal to the length register returns fault 1 (segment out of range).
- R3: A request to an in-range segment whose entry has its valid flag at 0 returns fault 2 (invalid segment).
- R4: A request whose offset is greater than or equal to the entry's limit returns fault 3 (offset beyond limit). A limit of 0 rejects every offset.
- R5: The access type is coded 00 read, 01 write, 10 execute and 11 reserved. The permission field is bit 0 read, bit 1 write and bit 2 execute. An access whose permission bit is clear returns fault 4. The reserved code is always denied.
- R6: When several checks fail, the lowest fault code wins: 1 before 2, 2 before 3, 3 before 4.
- R7: A request that passes every check returns fault 0 and a physical address equal to base plus offset, taken modulo 2^PA_W.
- R8: Each request yields exactly one response. `rsp_valid` is high in the cycle after `req_valid` and low in every other cycle.
- R9: A faulting response always drives `rsp_paddr` to 0.
- R10: A write to a table entry or to the length register applies to requests issued in the following cycle. A request issued in the same cycle as the write sees the old contents.
- R11: Writing one table entry leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside the block |
| cfg_entry_we | input | 1 | Write enable for the table entry at `cfg_entry_idx` |
| cfg_entry_idx | input | SEG_W | Index of the table entry to write |
| cfg_base | input | PA_W | Physical start address to store |
| cfg_limit | input | OFF_W+1 | Segment length in bytes to store |
| cfg_valid | input | 1 | Valid flag to store |
| cfg_perm | input | 3 | Permissions to store: bit 0 read, bit 1 write, bit 2 execute |
| cfg_len_we | input | 1 | Write enable for the length register |
| cfg_len | input | SEG_W+1 | Number of legal segments |
| req_valid | input | 1 | Translation request present |
| req_seg | input | SEG_W | Segment number of the request |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access type: 00 read, 01 write, 10 execute, 11 reserved |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_paddr | output | PA_W | Physical address, or 0 on a fault |
| rsp_fault | output | 3 | 0 none, 1 segment out of range, 2 invalid, 3 beyond limit, 4 permission denied |

## Verification
All outputs pass through a single register stage. Each result is therefore due on the rising edge that follows the edge at which the request is sampled, and table or length writes apply from that same edge onward. The driver applies inputs on the falling edge. It computes the expected fault and address from its own model of the table before it applies any write issued in the same cycle, and it queues the result. The monitor samples on the next falling edge, when the registered response is stable, and pairs each valid response with the oldest queued item. It flags any response that arrives with nothing queued, and any queued item still waiting when the run ends.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_RANGE   = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_LIMIT   = 3'd3,
    FLT_PERM    = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_RSV = 2'b11
  } acc_e;

  localparam int PERM_W  = 3;
  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_EX = 2;

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_COUNT = 8,
  parameter int SEG_W     = 3,
  parameter int LEN_W     = 4,
  parameter int PA_W      = 16,
  parameter int LIM_W     = 13,
  parameter int PERM_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_idx,
  input  logic [PA_W-1:0]   wr_base,
  input  logic [LIM_W-1:0]  wr_limit,
  input  logic              wr_valid,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic              len_we,
  input  logic [LEN_W-1:0]  len_din,
  input  logic [SEG_W-1:0]  rd_idx,
  output logic [PA_W-1:0]   rd_base,
  output logic [LIM_W-1:0]  rd_limit,
  output logic              rd_valid,
  output logic [PERM_W-1:0] rd_perm,
  output logic [LEN_W-1:0]  len_q
);
  logic [PA_W-1:0]   base_q  [SEG_COUNT];
  logic [LIM_W-1:0]  limit_q [SEG_COUNT];
  logic [PERM_W-1:0] perm_q  [SEG_COUNT];
  logic [SEG_COUNT-1:0] valid_q;

  logic [SEG_COUNT-1:0] ent_hit;
  logic [LEN_W-1:0]     len_d;

  // One write-select line per entry.
  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_sel
    assign ent_hit[g] = wr_en && (wr_idx == SEG_W'(g));
  end

  always_comb begin
    len_d = len_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SEG_COUNT; i++) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
        perm_q[i]  <= '0;
      end
      valid_q <= '0;
    end else begin
      for (int i = 0; i < SEG_COUNT; i++) begin
        if (ent_hit[i]) begin
          base_q[i]  <= wr_base;
          limit_q[i] <= wr_limit;
          perm_q[i]  <= wr_perm;
          valid_q[i] <= wr_valid;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_we) begin
      len_q <= len_d;
    end
  end

  assign rd_base  = base_q[rd_idx];
  assign rd_limit = limit_q[rd_idx];
  assign rd_perm  = perm_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 3,
  parameter int LEN_W  = 4,
  parameter int OFF_W  = 12,
  parameter int LIM_W  = 13,
  parameter int PA_W   = 16
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        acc,
  input  logic [LEN_W-1:0]  len,
  input  logic [PA_W-1:0]   base,
  input  logic [LIM_W-1:0]  limit,
  input  logic              valid,
  input  logic [PERM_W-1:0] perm,
  output fault_e            fault,
  output logic [PA_W-1:0]   paddr
);
  logic seg_ok;
  logic off_ok;
  logic perm_ok;

  always_comb begin
    seg_ok = LEN_W'(seg) < len;
    off_ok = LIM_W'(off) < limit;
    case (acc_e'(acc))
      ACC_RD:  perm_ok = perm[PERM_RD];
      ACC_WR:  perm_ok = perm[PERM_WR];
      ACC_EX:  perm_ok = perm[PERM_EX];
      default: perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (!seg_ok) begin
      fault = FLT_RANGE;
    end else if (!valid) begin
      fault = FLT_INVALID;
    end else if (!off_ok) begin
      fault = FLT_LIMIT;
    end else if (!perm_ok) begin
      fault = FLT_PERM;
    end else begin
      fault = FLT_NONE;
    end
    paddr = (fault == FLT_NONE) ? (base + PA_W'(off)) : '0;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_COUNT = 8,
  parameter int PA_W      = 16,
  parameter int OFF_W     = 12,
  localparam int SEG_W    = $clog2(SEG_COUNT),
  localparam int LEN_W    = SEG_W + 1,
  localparam int LIM_W    = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_entry_we,
  input  logic [SEG_W-1:0]  cfg_entry_idx,
  input  logic [PA_W-1:0]   cfg_base,
  input  logic [LIM_W-1:0]  cfg_limit,
  input  logic              cfg_valid,
  input  logic [2:0]        cfg_perm,
  input  logic              cfg_len_we,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [2:0]        rsp_fault
);
  logic              rst_sync_n;
  logic [PA_W-1:0]   ent_base;
  logic [LIM_W-1:0]  ent_limit;
  logic              ent_valid;
  logic [PERM_W-1:0] ent_perm;
  logic [LEN_W-1:0]  len_q;
  fault_e            chk_fault;
  logic [PA_W-1:0]   chk_paddr;

  logic              vld_q, vld_d;
  fault_e            fault_q, fault_d;
  logic [PA_W-1:0]   paddr_q, paddr_d;

  seg_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  seg_table #(
    .SEG_COUNT (SEG_COUNT),
    .SEG_W     (SEG_W),
    .LEN_W     (LEN_W),
    .PA_W      (PA_W),
    .LIM_W     (LIM_W),
    .PERM_W    (PERM_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (cfg_entry_we),
    .wr_idx   (cfg_entry_idx),
    .wr_base  (cfg_base),
    .wr_limit (cfg_limit),
    .wr_valid (cfg_valid),
    .wr_perm  (cfg_perm),
    .len_we   (cfg_len_we),
    .len_din  (cfg_len),
    .rd_idx   (req_seg),
    .rd_base  (ent_base),
    .rd_limit (ent_limit),
    .rd_valid (ent_valid),
    .rd_perm  (ent_perm),
    .len_q    (len_q)
  );

  seg_check #(
    .SEG_W (SEG_W),
    .LEN_W (LEN_W),
    .OFF_W (OFF_W),
    .LIM_W (LIM_W),
    .PA_W  (PA_W)
  ) u_check (
    .seg   (req_seg),
    .off   (req_off),
    .acc   (req_acc),
    .len   (len_q),
    .base  (ent_base),
    .limit (ent_limit),
    .valid (ent_valid),
    .perm  (ent_perm),
    .fault (chk_fault),
    .paddr (chk_paddr)
  );

  always_comb begin
    vld_d   = req_valid;
    fault_d = chk_fault;
    paddr_d = chk_paddr;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fault_q <= FLT_NONE;
      paddr_q <= '0;
    end else if (req_valid) begin
      fault_q <= fault_d;
      paddr_q <= paddr_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_fault = fault_q;
  assign rsp_paddr = paddr_q;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W = 3,
  parameter int LEN_W = 4,
  parameter int PA_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [SEG_W-1:0] req_seg,
  input logic [1:0]       req_acc,
  input logic [LEN_W-1:0] stl_len,
  input logic             rsp_valid,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic [2:0]       rsp_fault
);
  p_rsp_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_spurious_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_seg_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (LEN_W'(req_seg) >= stl_len)) |=> (rsp_fault == 3'd1));

  p_reserved_denied_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_acc == 2'b11)) |=> (rsp_fault != 3'd0));

  p_fault_zero_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_fault != 3'd0)) |-> (rsp_paddr == '0));

  p_fault_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault <= 3'd4));
endmodule

bind seg_xlate seg_xlate_chk #(
  .SEG_W (SEG_W),
  .LEN_W (LEN_W),
  .PA_W  (PA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid),
  .req_seg   (req_seg),
  .req_acc   (req_acc),
  .stl_len   (len_q),
  .rsp_valid (rsp_valid),
  .rsp_paddr (rsp_paddr),
  .rsp_fault (rsp_fault)
);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
  localparam int SEG_COUNT = 8;
  localparam int PA_W  = 16;
  localparam int OFF_W = 12;
  localparam int SEG_W = 3;
  localparam int LEN_W = 4;
  localparam int LIM_W = 13;

  logic             clk;
  logic             rst_n;
  logic             cfg_entry_we;
  logic [SEG_W-1:0] cfg_entry_idx;
  logic [PA_W-1:0]  cfg_base;
  logic [LIM_W-1:0] cfg_limit;
  logic             cfg_valid;
  logic [2:0]       cfg_perm;
  logic             cfg_len_we;
  logic [LEN_W-1:0] cfg_len;
  logic             req_valid;
  logic [SEG_W-1:0] req_seg;
  logic [OFF_W-1:0] req_off;
  logic [1:0]       req_acc;
  logic             rsp_valid;
  logic [PA_W-1:0]  rsp_paddr;
  logic [2:0]       rsp_fault;

  typedef struct {
    logic [2:0]      fault;
    logic [PA_W-1:0] paddr;
    string           tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   mon_on   = 0;

  // Bench model of the table, updated from the writes it issues.
  logic [PA_W-1:0]  m_base [SEG_COUNT];
  logic [LIM_W-1:0] m_lim  [SEG_COUNT];
  logic             m_val  [SEG_COUNT];
  logic [2:0]       m_perm [SEG_COUNT];
  int               m_len;

  seg_xlate #(.SEG_COUNT(SEG_COUNT), .PA_W(PA_W), .OFF_W(OFF_W)) i_seg_xlate (
    .clk(clk), .rst_n(rst_n),
    .cfg_entry_we(cfg_entry_we), .cfg_entry_idx(cfg_entry_idx),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_valid(cfg_valid),
    .cfg_perm(cfg_perm), .cfg_len_we(cfg_len_we), .cfg_len(cfg_len),
    .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic void predict(input int seg, input int off, input logic [1:0] acc,
                                  output logic [2:0] f, output logic [PA_W-1:0] pa);
    if (seg >= m_len)                           f = 3'd1;
    else if (!m_val[seg])                       f = 3'd2;
    else if (off >= int'(m_lim[seg]))           f = 3'd3;
    else if (acc == 2'b11 || !m_perm[seg][acc]) f = 3'd4;
    else                                        f = 3'd0;
    pa = (f == 3'd0) ? PA_W'(int'(m_base[seg]) + off) : '0;
  endfunction

  // One cycle of stimulus, applied on the falling edge.
  task automatic drive(input bit we, input int idx, input logic [PA_W-1:0] base,
                       input logic [LIM_W-1:0] lim, input bit v, input logic [2:0] perm,
                       input bit lwe, input int len,
                       input bit rv, input int seg, input int off,
                       input logic [1:0] acc, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_entry_we  = we;
    cfg_entry_idx = SEG_W'(idx);
    cfg_base      = base;
    cfg_limit     = lim;
    cfg_valid     = v;
    cfg_perm      = perm;
    cfg_len_we    = lwe;
    cfg_len       = LEN_W'(len);
    req_valid     = rv;
    req_seg       = SEG_W'(seg);
    req_off       = OFF_W'(off);
    req_acc       = acc;
    if (rv) begin
      predict(seg, off, acc, e.fault, e.paddr);
      e.tag = tag;
      exp_q.push_back(e);
    end
    if (we) begin
      m_base[idx] = base; m_lim[idx] = lim; m_val[idx] = v; m_perm[idx] = perm;
    end
    if (lwe) m_len = len;
  endtask

  task automatic wr_entry(input int idx, input logic [PA_W-1:0] base,
                          input logic [LIM_W-1:0] lim, input bit v, input logic [2:0] perm);
    drive(1, idx, base, lim, v, perm, 0, 0, 0, 0, 0, 2'b00, "");
  endtask

  task automatic req(input int seg, input int off, input logic [1:0] acc, input string tag);
    drive(0, 0, '0, '0, 0, 3'b000, 0, 0, 1, seg, off, acc, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++)
      drive(0, 0, '0, '0, 0, 3'b000, 0, 0, 0, 0, 0, 2'b00, "");
  endtask

  // Monitor: the response is due one clock after the request; sampled on the falling edge.
  always @(negedge clk) begin
    if (mon_on && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R8", "unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_fault == e.fault, e.tag, "fault", int'(rsp_fault), int'(e.fault));
        check(rsp_paddr == e.paddr, e.tag, "paddr", int'(rsp_paddr), int'(e.paddr));
      end
    end
  end

  initial begin
    #(20 * 200000);
    check(0, "watchdog", "run timed out", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < SEG_COUNT; i++) begin
      m_base[i] = '0; m_lim[i] = '0; m_val[i] = 0; m_perm[i] = '0;
    end
    m_len = 0;
    rst_n = 1'b0;
    cfg_entry_we = 0; cfg_entry_idx = '0; cfg_base = '0; cfg_limit = '0;
    cfg_valid = 0; cfg_perm = '0; cfg_len_we = 0; cfg_len = '0;
    req_valid = 0; req_seg = '0; req_off = '0; req_acc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);
    check(rsp_fault == 3'd0, "R1", "rsp_fault after reset", int'(rsp_fault), 0);
    mon_on = 1;

    req(0, 0, 2'b00, "R1 length zero");
    // R10: write of entry 0 and length together with a request sees old contents
    drive(1, 0, 16'h1000, 13'h100, 1, 3'b011, 1, 4, 1, 0, 16, 2'b00, "R10 same-cycle old");
    req(0, 16, 2'b00, "R10 next-cycle new / R7");
    req(2, 0, 2'b00, "R1 entry invalid after reset");
    wr_entry(1, 16'h2000, 13'h10, 0, 3'b111);
    req(1, 0, 2'b00, "R3 invalid entry");
    req(5, 0, 2'b00, "R2 above length");
    req(4, 0, 2'b00, "R2 equal to length");
    wr_entry(3, 16'hFF80, 13'h1000, 1, 3'b100);
    req(3, 12'hFFF, 2'b10, "R7 wrap at full limit");
    req(0, 12'h0FF, 2'b01, "R4 last legal offset");
    req(0, 12'h100, 2'b00, "R4 offset at limit");
    req(0, 5, 2'b10, "R5 execute denied");
    req(0, 5, 2'b11, "R5 reserved access");
    req(3, 5, 2'b00, "R5 read denied");
    req(3, 5, 2'b01, "R5 write denied");
    req(1, 12'h800, 2'b11, "R6 invalid beats limit and perm");
    req(0, 12'h800, 2'b10, "R6 limit beats perm");
    req(6, 12'h800, 2'b11, "R6 range beats all");
    wr_entry(2, 16'h4000, 13'h0, 1, 3'b111);
    req(2, 0, 2'b00, "R4 zero limit");
    req(0, 32, 2'b01, "R11 entry 0 kept");
    req(3, 0, 2'b10, "R11 entry 3 kept");
    idle(2);
    drive(0, 0, '0, '0, 0, 3'b000, 1, 1, 0, 0, 0, 2'b00, "");
    req(3, 0, 2'b10, "R10 length shrink");
    req(0, 1, 2'b00, "R10 seg 0 still legal");
    // Back-to-back stream
    drive(0, 0, '0, '0, 0, 3'b000, 1, 8, 0, 0, 0, 2'b00, "");
    for (int k = 0; k < 6; k++) req(k % 4, k * 7, 2'(k % 3), "R8 back-to-back");
    idle(3);
    check(exp_q.size() == 0, "R8", "missing responses", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule